// File: doc/BRIEF.md
# Page-Granular Compressed-Line Location Predictor

In a memory controller that packs pairs of compressible lines into one storage slot, a read must pick one of two places to fetch from: the paired (compressed) mapping or the ordinary base mapping. This block guesses that location before the access is issued, so that in the common case a single access is enough. It keeps one bit per table entry, the compressibility most recently seen for any line of a page that hashes to that entry. Nearby lines usually compress alike, so the last outcome on the page is a good guess for the next read.

The controller asks for a guess on the predict port and gets the answer one cycle later. When the fetched data has been examined and the real compressibility is known, the controller reports it on the update port, along with the guess it had used. The block overwrites the entry with the observed bit. When the guess was wrong it raises a one-cycle miss pulse, and the controller issues the second access to the other location. Two saturating counters total the predictions and the misses, so accuracy can be measured.

Top module: `llp_predictor`

## Requirements
- R1: After reset every table entry holds 0 (base mapping). `rsp_valid` is 0, `miss_valid` is 0, and both counters read 0.
- R2: A request with `pred_valid` high produces `rsp_valid` high on the next cycle. On that cycle `rsp_compressed` carries the entry bit, where 1 means the paired mapping and 0 means the base mapping. In any cycle where `rsp_valid` is low, `rsp_compressed` is 0.
- R3: The entry index is the XOR of address bits [21:12] and [31:22] (4 KB pages, 10-bit index, 1024 entries). Bits [11:0] have no effect on the index, and two pages whose index is equal share one entry.
- R4: An update with `upd_valid` high writes `upd_observed` into the entry of `upd_addr`. Every prediction requested in a later cycle sees the written value.
- R5: When a prediction and an update address the same entry in the same cycle, the prediction returns the value the entry held before that update.
- R6: `miss_valid` is high for exactly one cycle, on the cycle after an update whose `upd_predicted` differs from `upd_observed`. It is low in every other case, including updates whose guess was correct.
- R7: `pred_count` increments once for each cycle in which `pred_valid` is high. `miss_count` increments once for each mispredicted update. Both stop at their all-ones value and do not wrap.
- R8: With `upd_valid` low, the update inputs change no entry and raise no miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request |
| pred_addr | input | ADDR_W | Byte address of the line to be read |
| rsp_valid | output | 1 | Prediction result valid (one cycle after the request) |
| rsp_compressed | output | 1 | 1 = paired mapping, 0 = base mapping |
| upd_valid | input | 1 | Observed compressibility report |
| upd_addr | input | ADDR_W | Byte address of the line that was read |
| upd_observed | input | 1 | Compressibility found by the marker check |
| upd_predicted | input | 1 | Guess that was used for this read |
| miss_valid | output | 1 | One-cycle pulse: the guess was wrong, so a second access is needed |
| pred_count | output | CNT_W | Saturating count of predictions |
| miss_count | output | CNT_W | Saturating count of mispredictions |

## Verification
The hardest cases to reach are the ones that depend on sharing or timing. One is a read from a different page that lands on an entry another page wrote. Another is a prediction and an update hitting the same entry in the very same cycle. The bench builds aliasing addresses by swapping the two 10-bit page slices, and it drives the predict and update ports together on one edge. Counter saturation at 32 bits cannot be reached in a short run, so a second instance with 3-bit counters gets the same stimulus and is driven past its limit.

// File: rtl/llp_pkg.sv
package llp_pkg;
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_PAGE_SHIFT = 12;
    localparam int unsigned DEF_IDX_W      = 10;
    localparam int unsigned DEF_CNT_W      = 32;

    typedef enum logic {
        MAP_BASE   = 1'b0,
        MAP_PAIRED = 1'b1
    } map_e;

    typedef struct packed {
        logic rsp_valid;
        logic rsp_compressed;
        logic miss_valid;
    } out_state_t;
endpackage

// File: rtl/llp_page_hash.sv
module llp_page_hash #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned IDX_W      = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int unsigned NSLICE = (PAGE_W + IDX_W - 1) / IDX_W;
    localparam int unsigned PAD_W  = NSLICE * IDX_W;

    logic [PAD_W-1:0] page_pad;
    logic [IDX_W-1:0] fold [NSLICE+1];
    logic             unused_offset;

    assign unused_offset = ^addr[PAGE_SHIFT-1:0];

    always_comb begin
        page_pad = '0;
        page_pad[PAGE_W-1:0] = addr[ADDR_W-1:PAGE_SHIFT];
    end

    assign fold[0] = '0;
    for (genvar s = 0; s < NSLICE; s++) begin : g_fold
        assign fold[s+1] = fold[s] ^ page_pad[s*IDX_W +: IDX_W];
    end

    assign idx = fold[NSLICE];
endmodule

// File: rtl/llp_bit_table.sv
module llp_bit_table #(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            bits_d[wr_idx] = wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign rd_bit = bits_q[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits_q[$past(wr_idx)] == $past(wr_bit)); // R4

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits_q)); // R8
endmodule

// File: rtl/llp_sat_counter.sv
module llp_sat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q >= $past(cnt_q)); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/llp_predictor.sv
module llp_predictor #(
    parameter int unsigned ADDR_W     = llp_pkg::DEF_ADDR_W,
    parameter int unsigned PAGE_SHIFT = llp_pkg::DEF_PAGE_SHIFT,
    parameter int unsigned IDX_W      = llp_pkg::DEF_IDX_W,
    parameter int unsigned CNT_W      = llp_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              rsp_valid,
    output logic              rsp_compressed,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_observed,
    input  logic              upd_predicted,
    output logic              miss_valid,
    output logic [CNT_W-1:0]  pred_count,
    output logic [CNT_W-1:0]  miss_count
);
    import llp_pkg::*;

    logic [IDX_W-1:0] pred_idx, upd_idx;
    logic             entry_bit;
    logic             mispredict;
    out_state_t       st_d, st_q;

    llp_page_hash #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)) u_hash_pred (
        .addr (pred_addr),
        .idx  (pred_idx)
    );

    llp_page_hash #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)) u_hash_upd (
        .addr (upd_addr),
        .idx  (upd_idx)
    );

    llp_bit_table #(.IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_idx),
        .rd_bit (entry_bit),
        .wr_en  (upd_valid),
        .wr_idx (upd_idx),
        .wr_bit (upd_observed)
    );

    assign mispredict = upd_valid && (upd_observed != upd_predicted);

    llp_sat_counter #(.CNT_W(CNT_W)) u_pred_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pred_valid),
        .cnt   (pred_count)
    );

    llp_sat_counter #(.CNT_W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mispredict),
        .cnt   (miss_count)
    );

    always_comb begin
        st_d                = '0;
        st_d.rsp_valid      = pred_valid;
        st_d.rsp_compressed = pred_valid && (map_e'(entry_bit) == MAP_PAIRED);
        st_d.miss_valid     = mispredict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_compressed = st_q.rsp_compressed;
    assign miss_valid     = st_q.miss_valid;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |=> rsp_valid); // R2

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |=> !rsp_valid); // R2

    AST_RSP_BIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_compressed); // R2

    AST_MISS_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> !miss_valid); // R8

    AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_observed == upd_predicted) |=> !miss_valid); // R6
endmodule

// File: tb/llp_predictor_tb.sv
module llp_predictor_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pred_valid, upd_valid, upd_observed, upd_predicted;
    logic [31:0] pred_addr, upd_addr;
    logic        rsp_valid, rsp_compressed, miss_valid;
    logic [31:0] pred_count, miss_count;
    logic        s_rv, s_rc, s_mv;
    logic [2:0]  s_pc, s_mc;

    int checks = 0;
    int fails  = 0;
    bit model [1024];
    int exp_pred = 0;
    int exp_miss = 0;
    bit g_rv, g_rc, g_mv;

    always #5 clk = ~clk;

    llp_predictor u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_addr(pred_addr),
        .rsp_valid(rsp_valid), .rsp_compressed(rsp_compressed),
        .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_observed(upd_observed), .upd_predicted(upd_predicted),
        .miss_valid(miss_valid), .pred_count(pred_count), .miss_count(miss_count)
    );

    llp_predictor #(.CNT_W(3)) u_sat (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_addr(pred_addr),
        .rsp_valid(s_rv), .rsp_compressed(s_rc),
        .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_observed(upd_observed), .upd_predicted(upd_predicted),
        .miss_valid(s_mv), .pred_count(s_pc), .miss_count(s_mc)
    );

    function automatic int hidx(input logic [31:0] a);
        return int'(a[21:12] ^ a[31:22]);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pred_valid = 0; pred_addr = '0;
        upd_valid = 0; upd_addr = '0; upd_observed = 0; upd_predicted = 0;
    endtask

    // one cycle: drive at negedge, sample at following negedge, then advance model
    task automatic op(input bit pv, input logic [31:0] pa,
                      input bit uv, input logic [31:0] ua, input bit uo, input bit up);
        pred_valid = pv; pred_addr = pa;
        upd_valid = uv; upd_addr = ua; upd_observed = uo; upd_predicted = up;
        @(negedge clk);
        g_rv = rsp_valid; g_rc = rsp_compressed; g_mv = miss_valid;
        idle_inputs();
        if (pv) exp_pred++;
        if (uv) begin
            model[hidx(ua)] = uo;
            if (uo != up) exp_miss++;
        end
    endtask

    task automatic predict_check(input logic [31:0] a, input string tag);
        bit e;
        e = model[hidx(a)];
        op(1, a, 0, '0, 0, 0);
        check(g_rv == 1'b1, {tag, " rsp_valid"}, int'(g_rv), 1);
        check(g_rc == e, {tag, " rsp_compressed"}, int'(g_rc), int'(e));
    endtask

    task automatic t_reset();
        check(rsp_valid == 0 && rsp_compressed == 0, "R1 outputs idle", int'(rsp_valid), 0);
        check(miss_valid == 0, "R1 miss low", int'(miss_valid), 0);
        check(pred_count == 0 && miss_count == 0, "R1 counters", int'(pred_count + miss_count), 0);
        predict_check(32'h0000_0000, "R1 entry 0");
        predict_check(32'hFFFF_F000, "R1 entry 0");
        predict_check(32'h1234_5678, "R1 fresh entry");
        @(negedge clk);
        check(rsp_valid == 0 && rsp_compressed == 0, "R2 idle after response",
              int'({rsp_valid, rsp_compressed}), 0);
    endtask

    task automatic t_update_predict();
        op(0, '0, 1, 32'h0040_1000, 1, 0);
        check(g_mv == 1, "R6 miss after wrong guess", int'(g_mv), 1);
        @(negedge clk);
        check(miss_valid == 0, "R6 miss one cycle", int'(miss_valid), 0);
        predict_check(32'h0040_1000, "R4 written page");
        predict_check(32'h0040_1FC0, "R3 offset ignored");
        predict_check(32'h0040_2000, "R3 neighbour page");
        op(0, '0, 1, 32'h0040_1040, 0, 0);
        check(g_mv == 0, "R6 no miss on right guess", int'(g_mv), 0);
        predict_check(32'h0040_1000, "R4 cleared entry");
    endtask

    task automatic t_alias();
        // page slices 0x155 / 0x0AA swapped give the same index
        op(0, '0, 1, {10'h155, 10'h0AA, 12'h000}, 1, 1);
        check(g_mv == 0, "R6 matching guess", int'(g_mv), 0);
        predict_check({10'h0AA, 10'h155, 12'h7C0}, "R3 aliasing page");
        check(g_rc == 1, "R3 alias shares entry", int'(g_rc), 1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] a;
        a = 32'h00C0_3000;
        check(model[hidx(a)] == 0, "R5 precondition", int'(model[hidx(a)]), 0);
        op(1, a, 1, a, 1, 0);
        check(g_rc == 0, "R5 old value returned", int'(g_rc), 0);
        check(g_mv == 1, "R6 miss with prediction", int'(g_mv), 1);
        predict_check(a, "R5 new value later");
        check(g_rc == 1, "R5 entry now set", int'(g_rc), 1);
    endtask

    task automatic t_ignored_update();
        logic [31:0] a;
        a = 32'h0300_5000;
        pred_valid = 0; upd_valid = 0; upd_addr = a; upd_observed = 1; upd_predicted = 0;
        @(negedge clk);
        @(negedge clk);
        check(miss_valid == 0, "R8 no miss without valid", int'(miss_valid), 0);
        idle_inputs();
        predict_check(a, "R8 entry untouched");
        check(g_rc == 0, "R8 entry still base", int'(g_rc), 0);
    endtask

    task automatic t_counts();
        for (int i = 0; i < 4; i++) begin
            op(1, 32'h0100_0000 + i * 32'h1000, 1, 32'h0200_0000 + i * 32'h1000, 1, 0);
        end
        check(int'(pred_count) == exp_pred, "R7 prediction count", int'(pred_count), exp_pred);
        check(int'(miss_count) == exp_miss, "R7 miss count", int'(miss_count), exp_miss);
        check(int'(s_pc) == 7, "R7 small counter saturated", int'(s_pc), 7);
        check(int'(s_mc) == ((exp_miss > 7) ? 7 : exp_miss), "R7 small miss count",
              int'(s_mc), (exp_miss > 7) ? 7 : exp_miss);
        for (int i = 0; i < 5; i++) op(0, '0, 1, 32'h0500_0000, 0, 1);
        check(int'(s_mc) == 7, "R7 miss counter holds at max", int'(s_mc), 7);
        check(int'(miss_count) == exp_miss, "R7 miss count after more", int'(miss_count), exp_miss);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        for (int i = 0; i < 1024; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_update_predict();
        t_alias();
        t_same_cycle();
        t_ignored_update();
        t_counts();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule